// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from a reset or an accepted interrupt or trap request to the first fetch of the matching handler. After a reset it waits until the active-low reset input is released. It then reads the start address from vector slot 0 and hands that address to the core as the new program counter.

For an interrupt or trap it latches the current program counter, condition code register (CCR) and stack pointer. It pushes the program counter and then the CCR onto a downward-growing stack. It then computes the new interrupt mask and reads the handler address from the vector table at the vector number times four. At the end it hands the new PC, the new stack pointer and the new CCR back to the core in a single-cycle completion pulse.

Requests come in on a valid/ready pair. A source raises `exc_valid` with a vector number and holds both until a cycle in which `exc_ready` is also high. That cycle is the acceptance. While `exc_ready` is low the request is not taken and has no effect. Memory traffic goes out on a second valid/ready pair. The sequencer holds address, direction and write data steady until memory answers with `mem_ready`, and each access completes in the cycle in which both are high.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `mem_valid`, `exc_ready`, `done`, `sp_wr` and `ccr_wr` are all 0.
- R2: After `rst_n` goes high, the first memory request is a read (`mem_we`=0) at address 0. When that read completes, `done` pulses with `new_pc` equal to the data read, and `sp_wr` and `ccr_wr` stay 0.
- R3: `exc_ready` stays 0 from reset until the reset sequence's `done`, and for HOLD_CYC (default 4) further cycles after it. It becomes 1 in cycle HOLD_CYC+1 after the `done` cycle. A request that is raised and withdrawn inside this window starts no memory access.
- R4: An accepted request first writes the latched PC at stack pointer minus 4, then writes the latched CCR, zero-extended, at stack pointer minus 8.
- R5: With `ue` at 1 the new CCR equals the old CCR with bit 7 (I) set. With `ue` at 0 it equals the old CCR with bits 7 (I) and 6 (UI) set.
- R6: After the two pushes, the block reads at address vector×4. When that read completes, `done`, `sp_wr` and `ccr_wr` pulse together for one cycle, with `new_pc` equal to the read data and `new_sp` equal to the stack pointer minus 8.
- R7: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R8: Pulling `rst_n` low in the middle of an exception sequence abandons that sequence. The next memory request after release is the reset vector read at address 0.
- R9: `exc_ready` is 0 from acceptance of a request until its `done` cycle, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the reset sequence |
| exc_valid | input | 1 | Interrupt/trap request valid |
| exc_ready | output | 1 | Request can be accepted this cycle |
| exc_vec | input | VW | Vector number of the request |
| cur_pc | input | AW | Current program counter |
| cur_ccr | input | CW | Current condition code register |
| cur_sp | input | AW | Current stack pointer |
| ue | input | 1 | Mask-mode control: 1 sets I only, 0 sets I and UI |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted/complete |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, valid when mem_ready is high on a read |
| done | output | 1 | One-cycle pulse: new PC is valid |
| new_pc | output | AW | Handler or start address |
| sp_wr | output | 1 | Load new_sp into the stack pointer |
| new_sp | output | AW | Stack pointer after the pushes |
| ccr_wr | output | 1 | Load new_ccr into the CCR |
| new_ccr | output | CW | CCR with mask bits set |

## Verification
The assertions assume that memory never raises `mem_ready` unless a request is pending, and that `ue` and the `cur_*` inputs have settled by the acceptance cycle. The bench's memory model answers only after it has seen `mem_valid` at a falling edge, and it lowers `mem_ready` one cycle later. All other inputs change only at falling edges and stay steady for each whole request. The latency varies from zero to several cycles, so the stability property is exercised under back-pressure.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    S_RVEC     = 3'd0,
    S_IDLE     = 3'd1,
    S_PUSH_PC  = 3'd2,
    S_PUSH_CCR = 3'd3,
    S_MASK     = 3'd4,
    S_VEC      = 3'd5,
    S_DONE     = 3'd6
  } seq_state_t;
endpackage

// File: rtl/exc_mask_calc.sv
module exc_mask_calc #(
  parameter int CW     = 8,
  parameter int I_BIT  = 7,
  parameter int UI_BIT = 6
) (
  input  logic [CW-1:0] ccr_in,
  input  logic          ue,
  output logic [CW-1:0] ccr_out
);
  logic [CW-1:0] set_bits;
  for (genvar b = 0; b < CW; b++) begin : g_bit
    if (b == I_BIT) begin : g_i
      assign set_bits[b] = 1'b1;
    end else if (b == UI_BIT) begin : g_ui
      assign set_bits[b] = ~ue;
    end else begin : g_keep
      assign set_bits[b] = 1'b0;
    end
  end
  assign ccr_out = ccr_in | set_bits;
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen #(
  parameter int AW = 32,
  parameter int VW = 4
) (
  input  logic [AW-1:0] sp_base,
  input  logic [VW-1:0] vec_num,
  output logic [AW-1:0] pc_slot,
  output logic [AW-1:0] ccr_slot,
  output logic [AW-1:0] vec_addr
);
  localparam int          SLOT_BYTES = AW / 8;
  localparam logic [AW-1:0] SLOT    = AW'(SLOT_BYTES);
  localparam int          VSHIFT     = 2;

  assign pc_slot  = sp_base - SLOT;
  assign ccr_slot = sp_base - (SLOT << 1);
  assign vec_addr = AW'(vec_num) << VSHIFT;
endmodule

// File: rtl/exc_holdoff.sv
module exc_holdoff #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= HW'(HOLD_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
  assign active = (cnt != '0);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 8,
  parameter int VW       = 4,
  parameter int HOLD_CYC = 4,
  parameter int I_BIT    = 7,
  parameter int UI_BIT   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid,
  output logic          exc_ready,
  input  logic [VW-1:0] exc_vec,
  input  logic [AW-1:0] cur_pc,
  input  logic [CW-1:0] cur_ccr,
  input  logic [AW-1:0] cur_sp,
  input  logic          ue,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] new_pc,
  output logic          sp_wr,
  output logic [AW-1:0] new_sp,
  output logic          ccr_wr,
  output logic [CW-1:0] new_ccr
);
  seq_state_t    state;
  logic [VW-1:0] vec_q;
  logic [AW-1:0] pc_q, sp_q, pc_new_q;
  logic [CW-1:0] ccr_q, ccr_new_q;
  logic          ue_q, from_rst;
  logic [AW-1:0] pc_slot, ccr_slot, vec_addr;
  logic [CW-1:0] ccr_masked;
  logic          hold_active;
  logic          accept, xfer, rst_done;

  exc_addr_gen #(.AW(AW), .VW(VW)) u_addr (
    .sp_base (sp_q),
    .vec_num (vec_q),
    .pc_slot (pc_slot),
    .ccr_slot(ccr_slot),
    .vec_addr(vec_addr)
  );

  exc_mask_calc #(.CW(CW), .I_BIT(I_BIT), .UI_BIT(UI_BIT)) u_mask (
    .ccr_in (ccr_q),
    .ue     (ue_q),
    .ccr_out(ccr_masked)
  );

  assign rst_done = (state == S_DONE) && from_rst;

  exc_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_done),
    .active(hold_active)
  );

  assign exc_ready = rst_n && (state == S_IDLE) && !hold_active;
  assign accept    = exc_valid && exc_ready;
  assign xfer      = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RVEC;
      from_rst  <= 1'b1;
      vec_q     <= '0;
      pc_q      <= '0;
      sp_q      <= '0;
      ccr_q     <= '0;
      ue_q      <= 1'b0;
      pc_new_q  <= '0;
      ccr_new_q <= '0;
    end else begin
      case (state)
        S_RVEC: if (xfer) begin
          pc_new_q <= mem_rdata;
          state    <= S_DONE;
        end
        S_IDLE: if (accept) begin
          vec_q    <= exc_vec;
          pc_q     <= cur_pc;
          sp_q     <= cur_sp;
          ccr_q    <= cur_ccr;
          ue_q     <= ue;
          from_rst <= 1'b0;
          state    <= S_PUSH_PC;
        end
        S_PUSH_PC:  if (xfer) state <= S_PUSH_CCR;
        S_PUSH_CCR: if (xfer) state <= S_MASK;
        S_MASK: begin
          ccr_new_q <= ccr_masked;
          state     <= S_VEC;
        end
        S_VEC: if (xfer) begin
          pc_new_q <= mem_rdata;
          state    <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (rst_n) begin
      case (state)
        S_RVEC: begin
          mem_valid = 1'b1;
          mem_addr  = '0;
        end
        S_PUSH_PC: begin
          mem_valid = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = pc_slot;
          mem_wdata = pc_q;
        end
        S_PUSH_CCR: begin
          mem_valid = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = ccr_slot;
          mem_wdata = AW'(ccr_q);
        end
        S_VEC: begin
          mem_valid = 1'b1;
          mem_addr  = vec_addr;
        end
        default: ;
      endcase
    end
  end

  assign done    = rst_n && (state == S_DONE);
  assign sp_wr   = done && !from_rst;
  assign ccr_wr  = done && !from_rst;
  assign new_pc  = pc_new_q;
  assign new_sp  = ccr_slot;
  assign new_ccr = ccr_new_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int AW       = 32,
  parameter int CW       = 8,
  parameter int HOLD_CYC = 4,
  parameter int I_BIT    = 7,
  parameter int UI_BIT   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_valid,
  input logic          exc_ready,
  input logic          ue,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          done,
  input logic          sp_wr,
  input logic          ccr_wr,
  input logic [CW-1:0] new_ccr
);
  localparam int HW = $clog2(HOLD_CYC + 2);
  logic          in_rst_seq, busy, ue_seen;
  logic [HW-1:0] blk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst_seq <= 1'b1;
      blk_cnt    <= '0;
      busy       <= 1'b0;
      ue_seen    <= 1'b0;
    end else begin
      if (done && in_rst_seq) begin
        in_rst_seq <= 1'b0;
        blk_cnt    <= HW'(HOLD_CYC);
      end else if (blk_cnt != '0) begin
        blk_cnt <= blk_cnt - 1'b1;
      end
      if (exc_valid && exc_ready) begin
        busy    <= 1'b1;
        ue_seen <= ue;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!mem_valid && !exc_ready && !done);
    end
  end

  a_r3_blocked_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rst_seq || blk_cnt != '0) |-> !exc_ready);

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !exc_ready);

  a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_updates_together: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr || ccr_wr) |-> (done && sp_wr && ccr_wr));

  a_r2_reset_no_state_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && in_rst_seq) |-> (!sp_wr && !ccr_wr));

  a_r5_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_wr |-> (new_ccr[I_BIT] && (ue_seen || new_ccr[UI_BIT])));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .AW(AW), .CW(CW), .HOLD_CYC(HOLD_CYC), .I_BIT(I_BIT), .UI_BIT(UI_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exc_valid(exc_valid),
  .exc_ready(exc_ready),
  .ue       (ue),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .done     (done),
  .sp_wr    (sp_wr),
  .ccr_wr   (ccr_wr),
  .new_ccr  (new_ccr)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int AW = 32, CW = 8, VW = 4, HOLD_CYC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exc_valid = 1'b0;
  logic          exc_ready;
  logic [VW-1:0] exc_vec = '0;
  logic [AW-1:0] cur_pc = '0;
  logic [CW-1:0] cur_ccr = '0;
  logic [AW-1:0] cur_sp = '0;
  logic          ue = 1'b0;
  logic          mem_valid, mem_we;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr, mem_wdata;
  logic [AW-1:0] mem_rdata = '0;
  logic          done, sp_wr, ccr_wr;
  logic [AW-1:0] new_pc, new_sp;
  logic [CW-1:0] new_ccr;

  int n_run = 0, n_fail = 0;
  bit wd_hit = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_seq #(.AW(AW), .CW(CW), .VW(VW), .HOLD_CYC(HOLD_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
    .exc_vec(exc_vec), .cur_pc(cur_pc), .cur_ccr(cur_ccr), .cur_sp(cur_sp),
    .ue(ue), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .new_pc(new_pc), .sp_wr(sp_wr), .new_sp(new_sp),
    .ccr_wr(ccr_wr), .new_ccr(new_ccr)
  );

  typedef struct packed {
    logic [3:0]  vec;
    logic [31:0] pc;
    logic [7:0]  ccr;
    logic [31:0] sp;
    logic        uev;
    logic [2:0]  lat;
  } row_t;

  localparam row_t TBL [5] = '{
    '{vec: 4'd3,  pc: 32'h0000_1234, ccr: 8'h05, sp: 32'h0000_FF00, uev: 1'b1, lat: 3'd0},
    '{vec: 4'd7,  pc: 32'h00AB_CDE0, ccr: 8'h00, sp: 32'h0001_0000, uev: 1'b0, lat: 3'd2},
    '{vec: 4'd12, pc: 32'h0000_0042, ccr: 8'h80, sp: 32'h0000_2008, uev: 1'b0, lat: 3'd1},
    '{vec: 4'd15, pc: 32'hFFFF_FFFC, ccr: 8'h3F, sp: 32'h0000_0010, uev: 1'b1, lat: 3'd4},
    '{vec: 4'd1,  pc: 32'h0000_0100, ccr: 8'hC0, sp: 32'h8000_0000, uev: 1'b0, lat: 3'd3}
  };

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return 32'h5A00_0000 ^ (a << 4) ^ 32'h0000_0003;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serve(input int lat, output logic we, output logic [31:0] addr,
                       output logic [31:0] wdata);
    int guard = 0;
    while (!mem_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    we = mem_we; addr = mem_addr; wdata = mem_wdata;
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rdata = table_word(mem_addr);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic run_reset_seq();
    logic we; logic [31:0] a, d;
    serve(1, we, a, d);
    check(we == 1'b0 && a == 32'h0, "R2 reset vector read", {31'b0, we} ^ a, 32'h0);
    check(done == 1'b1, "R2 done after reset vector", {31'b0, done}, 32'h1);
    check(new_pc == table_word(32'h0), "R2 start address", new_pc, table_word(32'h0));
    check(!sp_wr && !ccr_wr, "R2 no sp/ccr write", {30'b0, sp_wr, ccr_wr}, 32'h0);
  endtask

  task automatic wait_hold();
    for (int k = 0; k < HOLD_CYC; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_row(input row_t r);
    logic we; logic [31:0] a, d;
    logic [7:0] exp_ccr;
    exp_ccr = r.ccr | 8'h80 | (r.uev ? 8'h00 : 8'h40);
    exc_vec = r.vec; cur_pc = r.pc; cur_ccr = r.ccr; cur_sp = r.sp; ue = r.uev;
    exc_valid = 1'b1;
    check(exc_ready == 1'b1, "R9 ready when idle", {31'b0, exc_ready}, 32'h1);
    @(negedge clk);
    exc_valid = 1'b0;
    check(exc_ready == 1'b0, "R9 not ready while busy", {31'b0, exc_ready}, 32'h0);
    serve(r.lat, we, a, d);
    check(we && a == r.sp - 32'd4, "R4 pc push addr", a, r.sp - 32'd4);
    check(d == r.pc, "R4 pc push data", d, r.pc);
    serve(r.lat, we, a, d);
    check(we && a == r.sp - 32'd8, "R4 ccr push addr", a, r.sp - 32'd8);
    check(d == {24'h0, r.ccr}, "R4 ccr push data", d, {24'h0, r.ccr});
    serve(r.lat, we, a, d);
    check(!we && a == {26'h0, r.vec, 2'b00}, "R6 vector read addr", a, {26'h0, r.vec, 2'b00});
    check(done && sp_wr && ccr_wr, "R6 done pulse", {29'b0, done, sp_wr, ccr_wr}, 32'h7);
    check(new_pc == table_word(a), "R6 new pc", new_pc, table_word(a));
    check(new_sp == r.sp - 32'd8, "R6 new sp", new_sp, r.sp - 32'd8);
    check(new_ccr == exp_ccr, "R5 mask update", {24'h0, new_ccr}, {24'h0, exp_ccr});
    @(negedge clk);
    check(!done, "R6 done single cycle", {31'b0, done}, 32'h0);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin : main
    logic we; logic [31:0] a, d;
    fork
      begin
        repeat (3) @(negedge clk);
        check(!mem_valid && !exc_ready && !done && !sp_wr && !ccr_wr, "R1 quiet in reset",
              {27'b0, mem_valid, exc_ready, done, sp_wr, ccr_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(exc_ready == 1'b0, "R3 blocked in reset seq", {31'b0, exc_ready}, 32'h0);
        run_reset_seq();
        for (int k = 0; k < HOLD_CYC; k++) begin
          @(negedge clk);
          check(exc_ready == 1'b0, "R3 holdoff", {31'b0, exc_ready}, 32'h0);
          if (k == 1) exc_valid = 1'b1;
          if (k == 2) exc_valid = 1'b0;
          check(mem_valid == 1'b0, "R3 request ignored", {31'b0, mem_valid}, 32'h0);
        end
        @(negedge clk);
        check(exc_ready == 1'b1, "R3 ready after holdoff", {31'b0, exc_ready}, 32'h1);
        check(mem_valid == 1'b0, "R3 no access started", {31'b0, mem_valid}, 32'h0);

        for (int i = 0; i < 5; i++) run_row(TBL[i]);

        // R8: abort mid-sequence
        exc_vec = 4'd9; cur_pc = 32'h0000_7770; cur_ccr = 8'h01; cur_sp = 32'h0000_4000; ue = 1'b1;
        exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
        serve(0, we, a, d);
        rst_n = 1'b0;
        #1;
        check(!mem_valid && !exc_ready && !done, "R1 quiet on mid-sequence reset",
              {29'b0, mem_valid, exc_ready, done}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid && !mem_we && mem_addr == 32'h0, "R8 restart at reset vector",
              mem_addr, 32'h0);
        run_reset_seq();
        wait_hold();
        run_row(TBL[1]);
      end
      begin
        wait (wd_hit);
      end
    join_any
    if (wd_hit) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule